// File: doc/BRIEF.md
# Discrete PID Controller Datapath

This block is a fixed-point discrete PID controller in parallel form. Each time a sample strobe arrives, it takes one signed error word and builds three actions side by side: a proportional action, a recursive trapezoidal integral action, and a derivative action that passes through a first-order filter and feeds back its own previous value. The three actions are added and clamped to the output width. The sum is then registered and flagged valid on the following clock.

All gains reach the block as signed run-time integers that share a fixed-point scale of 10000, so 10000 means a gain of 1.0. A stimulus or configuration source supplies them. The input side works like a valid-only stream: `smp_en` is the valid strobe, and the block takes every strobe with no back-pressure, so it has no ready signal. `u_valid` pulses for exactly one clock for each accepted sample. The consumer must take `u_out` during that clock, although `u_out` holds its value until the next sample. Between strobes the gain inputs and the error input may change freely.

Top module: `pid_datapath`

## Requirements
- R1: On each sample the output is the saturated sum of the proportional, integral and derivative actions computed for that same sample.
- R2: The proportional action is (kp_coef × e[k]) / 10000, where every coefficient is a signed integer scaled by 10000.
- R3: The integral action is I[k] = I[k−1] + (ki_coef × (e[k] + e[k−1])) / 10000. e[k−1] is the error taken at the previous sample.
- R4: The integral state saturates at the signed bounds of the AW-bit accumulator (default 32 bits), so it never wraps.
- R5: The derivative action is D[k] = (kd_pole × D[k−1]) / 10000 + (kd_coef × (e[k] − e[k−1])) / 10000, saturated to AW bits.
- R6: The final sum saturates to the OW-bit signed output range (default −32768 to 32767).
- R7: `u_valid` is high for exactly the one clock after each clock in which `smp_en` was high, and low otherwise.
- R8: The previous-error, integral and derivative state and `u_out` change only on a sample. On cycles without `smp_en`, changes on `err_in` or on the coefficients have no effect.
- R9: Active-low reset clears the previous error, the integral, the derivative, `u_out` and `u_valid` to zero.
- R10: Each scaled product is divided by 10000 with truncation toward zero. The division happens before the product is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe (input valid); always accepted |
| err_in | input | EW (16) | Signed error sample |
| kp_coef | input | CW (20) | Proportional gain, signed, scale 10000 |
| ki_coef | input | CW (20) | Trapezoidal integral coefficient, signed, scale 10000 |
| kd_pole | input | CW (20) | Derivative feedback coefficient, signed, scale 10000 |
| kd_coef | input | CW (20) | Derivative difference coefficient, signed, scale 10000 |
| u_out | output | OW (16) | Saturated control output |
| u_valid | output | 1 | One-clock pulse marking a new `u_out` |

## Verification
The bench holds the largest positive error on a maximal integral coefficient for hundreds of samples, then reverses the error. An accumulator that wraps instead of clamping would swing the output from full positive to full negative partway through. An odd negative product checks truncation toward zero: a design that floors the division would come out one count low. The bench also drives large sums past the output range, where a missing clamp shows up as a sign flip. Between strobes it changes the inputs and then repeats a reset. A design that updated its state without a strobe, or that cleared only part of its state on reset, would drift away from the bench's reference sequence.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam longint SCALE = 10000;

  typedef logic signed [63:0] wide_t;

  // scaled product, quotient truncated toward zero
  function automatic wide_t scl_mul(input wide_t a, input wide_t b);
    wide_t prod;
    prod = a * b;
    return prod / wide_t'(SCALE);
  endfunction

  // clamp to a signed range of w bits
  function automatic wide_t sat_w(input wide_t v, input int w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/pid_prop_term.sv
module pid_prop_term
  import pid_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 20
) (
  input  logic signed [EW-1:0] err,
  input  logic signed [CW-1:0] kp,
  output wide_t                p_val
);
  wide_t e_w;
  wide_t k_w;

  always_comb begin
    e_w   = wide_t'(err);
    k_w   = wide_t'(kp);
    p_val = scl_mul(k_w, e_w);
  end
endmodule

// File: rtl/pid_int_term.sv
module pid_int_term
  import pid_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 20,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [EW-1:0] err,
  input  logic signed [EW-1:0] err_prev,
  input  logic signed [CW-1:0] ki,
  output logic signed [AW-1:0] i_q,
  output wide_t                i_next
);
  wide_t trap_sum;
  wide_t step;

  always_comb begin
    trap_sum = wide_t'(err) + wide_t'(err_prev);
    step     = scl_mul(wide_t'(ki), trap_sum);
    i_next   = sat_w(wide_t'(i_q) + step, AW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  i_q <= '0;
    else if (en) i_q <= i_next[AW-1:0];
  end
endmodule

// File: rtl/pid_der_term.sv
module pid_der_term
  import pid_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 20,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [EW-1:0] err,
  input  logic signed [EW-1:0] err_prev,
  input  logic signed [CW-1:0] pole,
  input  logic signed [CW-1:0] kd,
  output logic signed [AW-1:0] d_q,
  output wide_t                d_next
);
  wide_t fb_part;
  wide_t diff_part;

  always_comb begin
    fb_part   = scl_mul(wide_t'(pole), wide_t'(d_q));
    diff_part = scl_mul(wide_t'(kd), wide_t'(err) - wide_t'(err_prev));
    d_next    = sat_w(fb_part + diff_part, AW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  d_q <= '0;
    else if (en) d_q <= d_next[AW-1:0];
  end
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 20,
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic signed [EW-1:0] err_in,
  input  logic signed [CW-1:0] kp_coef,
  input  logic signed [CW-1:0] ki_coef,
  input  logic signed [CW-1:0] kd_pole,
  input  logic signed [CW-1:0] kd_coef,
  output logic signed [OW-1:0] u_out,
  output logic                 u_valid
);
  logic signed [EW-1:0] e_prev;
  logic signed [AW-1:0] i_acc;
  logic signed [AW-1:0] d_acc;
  wide_t                p_val;
  wide_t                i_next;
  wide_t                d_next;
  wide_t                u_sum;

  pid_prop_term #(.EW(EW), .CW(CW)) u_prop (
    .err   (err_in),
    .kp    (kp_coef),
    .p_val (p_val)
  );

  pid_int_term #(.EW(EW), .CW(CW), .AW(AW)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (smp_en),
    .err      (err_in),
    .err_prev (e_prev),
    .ki       (ki_coef),
    .i_q      (i_acc),
    .i_next   (i_next)
  );

  pid_der_term #(.EW(EW), .CW(CW), .AW(AW)) u_der (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (smp_en),
    .err      (err_in),
    .err_prev (e_prev),
    .pole     (kd_pole),
    .kd       (kd_coef),
    .d_q      (d_acc),
    .d_next   (d_next)
  );

  always_comb u_sum = sat_w(p_val + i_next + d_next, OW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_prev  <= '0;
      u_out   <= '0;
      u_valid <= 1'b0;
    end else begin
      u_valid <= smp_en;
      if (smp_en) begin
        e_prev <= err_in;
        u_out  <= u_sum[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/pid_datapath_chk.sv
module pid_datapath_chk #(
  parameter int EW = 16,
  parameter int AW = 32,
  parameter int OW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_en,
  input logic signed [EW-1:0] err_in,
  input logic signed [EW-1:0] e_prev,
  input logic signed [AW-1:0] i_acc,
  input logic signed [AW-1:0] d_acc,
  input logic signed [OW-1:0] u_out,
  input logic                 u_valid
);
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) smp_en |=> u_valid); // R7
  AST_VALID_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> !u_valid); // R7
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> $stable(u_out)); // R8
  AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> $stable(i_acc)); // R8
  AST_DER_HELD: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> $stable(d_acc)); // R8
  AST_PREV_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) smp_en |=> (e_prev == $past(err_in))); // R3
endmodule

bind pid_datapath pid_datapath_chk #(.EW(EW), .AW(AW), .OW(OW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_en  (smp_en),
  .err_in  (err_in),
  .e_prev  (e_prev),
  .i_acc   (i_acc),
  .d_acc   (d_acc),
  .u_out   (u_out),
  .u_valid (u_valid)
);

// File: tb/pid_datapath_tb.sv
`timescale 1ns/1ps
module pid_datapath_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_en = 1'b0;
  logic signed [15:0] err_in = '0;
  logic signed [19:0] kp_coef = '0;
  logic signed [19:0] ki_coef = '0;
  logic signed [19:0] kd_pole = '0;
  logic signed [19:0] kd_coef = '0;
  logic signed [15:0] u_out;
  logic               u_valid;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  longint m_ep = 0, m_i = 0, m_d = 0, m_u = 0;

  always #4 clk = ~clk;

  pid_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .err_in(err_in),
    .kp_coef(kp_coef), .ki_coef(ki_coef), .kd_pole(kd_pole), .kd_coef(kd_coef),
    .u_out(u_out), .u_valid(u_valid)
  );

  function automatic longint smul(longint a, longint b);
    return (a * b) / 64'sd10000;
  endfunction

  function automatic longint clampw(longint v, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_gains(int kp, int ki, int kpole, int kd);
    kp_coef = 20'(kp); ki_coef = 20'(ki); kd_pole = 20'(kpole); kd_coef = 20'(kd);
  endtask

  // one sample: drive at negedge, compare at the following negedge
  task automatic sample(int e, string req);
    longint p, ni, nd;
    err_in = 16'(e);
    smp_en = 1'b1;
    p  = smul(longint'(kp_coef), longint'(err_in));
    ni = clampw(m_i + smul(longint'(ki_coef), longint'(err_in) + m_ep), 32);
    nd = clampw(smul(longint'(kd_pole), m_d) + smul(longint'(kd_coef), longint'(err_in) - m_ep), 32);
    m_u = clampw(p + ni + nd, 16);
    m_i = ni; m_d = nd; m_ep = longint'(err_in);
    @(negedge clk);
    smp_en = 1'b0;
    check({req, " R7 valid"}, longint'(u_valid), 1);
    check(req, longint'(u_out), m_u);
  endtask

  // idle cycle with disturbed inputs: nothing may move
  task automatic idle_disturb();
    err_in  = 16'($urandom_range(0, 65535));
    kp_coef = 20'($urandom_range(0, 1048575));
    @(negedge clk);
    check("R7 idle valid", longint'(u_valid), 0);
    check("R8 idle hold", longint'(u_out), m_u);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ep = 0; m_i = 0; m_d = 0; m_u = 0;
    check("R9 reset out", longint'(u_out), 0);
    check("R9 reset valid", longint'(u_valid), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();

    // R2 proportional only
    set_gains(10000, 0, 0, 0);
    sample(1234, "R2 unity kp");
    set_gains(25000, 0, 0, 0);
    sample(-400, "R2 kp 2.5");
    // R10: 7 * -1.5 = -10.5 must become -10
    set_gains(-15000, 0, 0, 0);
    sample(7, "R10 trunc toward zero");
    sample(-7, "R10 trunc positive");

    // R3 trapezoidal integral
    do_reset();
    set_gains(0, 300, 0, 0);
    sample(1000, "R3 integral 1");
    sample(1000, "R3 integral 2");
    sample(-500, "R3 integral 3");
    idle_disturb();
    set_gains(0, 300, 0, 0);
    sample(200, "R3 integral after idle");

    // R5 filtered derivative impulse
    do_reset();
    set_gains(0, 0, 7143, 20000);
    sample(3000, "R5 derivative step");
    sample(3000, "R5 derivative decay 1");
    sample(3000, "R5 derivative decay 2");
    sample(0, "R5 derivative drop");

    // R1 all three, reference-like set
    do_reset();
    set_gains(10000, 300, 7143, 30000);
    for (int k = 0; k < 20; k++) sample(1000, "R1 step response");

    // R6 output clamp both directions
    do_reset();
    set_gains(200000, 0, 0, 0);
    sample(20000, "R6 clamp high");
    sample(-20000, "R6 clamp low");

    // R4 integral wind-up against the accumulator bound
    do_reset();
    set_gains(0, 524287, 0, 0);
    for (int k = 0; k < 700; k++) sample(32767, "R4 wind up");
    for (int k = 0; k < 40; k++) sample(-32768, "R4 unwind");

    // R9 reset mid-run clears all state
    set_gains(10000, 300, 5000, 10000);
    sample(5000, "R9 pre reset");
    do_reset();
    sample(100, "R9 state cleared");

    // random mix, R1
    do_reset();
    for (int k = 0; k < 400; k++) begin
      set_gains(int'($urandom_range(0, 60000)) - 30000, int'($urandom_range(0, 2000)) - 1000,
                int'($urandom_range(0, 19998)) - 9999, int'($urandom_range(0, 100000)) - 50000);
      sample(int'($urandom_range(0, 65535)) - 32768, "R1 random");
      if ($urandom_range(0, 3) == 0) idle_disturb();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule